// File: doc/BRIEF.md
# Per-Bank DRAM RAS Timing Sequencer

This block drives the row strobes of a four-bank DRAM array and paces every access and refresh in CPU input clock cycles. Each bank carries three 2-bit timing codes of its own: the wait states added before an access is acknowledged, the precharge lockout that follows the release of its row strobe, and the width of a refresh strobe. An access request names a bank. The sequencer raises that bank's strobe and counts the decoded wait states. It then gives a one-cycle acknowledge, drops the strobe and locks the bank for its precharge time.

A refresh request also names a bank. It yields a strobe whose width comes from that bank's refresh code, followed by the same precharge lockout. Requests are level signals that the requester holds until the matching acknowledge or done pulse. A request to a bank that is still precharging simply waits. A different bank can be opened one cycle after the previous strobe falls. At most one strobe is active at a time.

Top module: `dram_ras_seq`

## Requirements
- R1: An access to bank b holds ras_o[b] high for W+1 cycles, where W is the bank's wait-state code decoded as 00b=3, 01b=4, 10b=5. acc_ack_o is high in the last of those cycles, W cycles after the strobe first goes high.
- R2: The reserved wait-state code 11b behaves exactly like 10b: 5 wait states.
- R3: acc_ack_o is high for exactly one cycle per access and only while a strobe is high.
- R4: After ras_o[b] falls, it stays low for at least P cycles, where P is the bank's precharge code decoded as 00b=4, 01b=6, 10b=8, 11b=8. A request held for bank b rises again after exactly P low cycles.
- R5: A refresh of bank b holds ras_o[b] high for 4+code cycles of the bank's refresh code. ref_done_o pulses once, in the last of those cycles.
- R6: A request to a bank other than the one just closed is started one cycle after the previous strobe falls, regardless of the closed bank's precharge.
- R7: When both requests are pending while the sequencer is idle, the refresh is started first. The access follows after the refresh completes.
- R8: At most one bit of ras_o is high in any cycle.
- R9: While reset is applied, every strobe is low and neither acc_ack_o nor ref_done_o is high.
- R10: The timing of bank b depends only on bank b's codes. The codes of other banks have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU input clock (CLK2 domain) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wait_i | input | 8 | Wait-state codes, bits [2b+1:2b] for bank b |
| cfg_pre_i | input | 8 | Precharge codes, bits [2b+1:2b] for bank b |
| cfg_rfw_i | input | 8 | Refresh-width codes, bits [2b+1:2b] for bank b |
| acc_req_i | input | 1 | Access request, held until acc_ack_o |
| acc_bank_i | input | 2 | Bank targeted by the access |
| ref_req_i | input | 1 | Refresh request, held until ref_done_o |
| ref_bank_i | input | 2 | Bank targeted by the refresh |
| ras_o | output | 4 | Row strobes, active high, one per bank |
| acc_ack_o | output | 1 | One-cycle access ready |
| ref_done_o | output | 1 | One-cycle refresh completion |

## Verification
Every bank is swept through all four values of one code while the other three banks are loaded with the opposite code. A decode error, or a mux that reads a neighbour's field, then shows as a wrong strobe length or gap. Back-to-back requests to the same bank measure the precharge lockout to the exact cycle. A request to the next bank on the closing edge shows that the lockout is kept per bank and not shared. Requests for a refresh and an access raised in the same cycle to different idle banks separate a correct arbitration order from one that favours the access.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int CODE_W = 2;
  localparam int CNT_W  = 4;

  typedef logic [CNT_W-1:0] cyc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_REF  = 2'd2
  } seq_state_e;

  // wait states before ready; reserved code falls back to the longest
  function automatic cyc_t ws_decode(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   return cyc_t'(3);
      2'b01:   return cyc_t'(4);
      default: return cyc_t'(5);
    endcase
  endfunction

  // precharge lockout, top two codes share the same length
  function automatic cyc_t pre_decode(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   return cyc_t'(4);
      2'b01:   return cyc_t'(6);
      default: return cyc_t'(8);
    endcase
  endfunction

  // refresh strobe width grows linearly from four cycles
  function automatic cyc_t rfw_decode(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   return cyc_t'(4);
      2'b01:   return cyc_t'(5);
      2'b10:   return cyc_t'(6);
      default: return cyc_t'(7);
    endcase
  endfunction

endpackage

// File: rtl/dram_timing_decode.sv
module dram_timing_decode
  import dram_seq_pkg::*;
#(
  parameter  int NBANK = 4,
  localparam int CFG_W = CODE_W * NBANK
) (
  input  logic [CFG_W-1:0] cfg_wait_i,
  input  logic [CFG_W-1:0] cfg_pre_i,
  input  logic [CFG_W-1:0] cfg_rfw_i,
  output cyc_t             wait_o [NBANK],
  output cyc_t             pre_o  [NBANK],
  output cyc_t             rfw_o  [NBANK]
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign wait_o[b] = ws_decode (cfg_wait_i[CODE_W*b +: CODE_W]);
    assign pre_o[b]  = pre_decode(cfg_pre_i [CODE_W*b +: CODE_W]);
    assign rfw_o[b]  = rfw_decode(cfg_rfw_i [CODE_W*b +: CODE_W]);
  end

endmodule

// File: rtl/dram_bank_lock.sv
module dram_bank_lock
  import dram_seq_pkg::*;
#(
  parameter  int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_i,
  input  logic [BANK_W-1:0] close_bank_i,
  input  cyc_t              pre_i [NBANK],
  output logic [NBANK-1:0]  ready_o
);

  for (genvar b = 0; b < NBANK; b++) begin : g_lock
    cyc_t cnt_q, cnt_d;
    logic load, cnt_en;

    always_comb begin
      load   = close_i && (close_bank_i == BANK_W'(b));
      cnt_en = load || (cnt_q != '0);
      cnt_d  = load ? pre_i[b] : (cnt_q - cyc_t'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    // the strobe may rise on the edge where the count leaves 1
    assign ready_o[b] = (cnt_q <= cyc_t'(1));
  end

endmodule

// File: rtl/dram_ras_fsm.sv
module dram_ras_fsm
  import dram_seq_pkg::*;
#(
  parameter  int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req_i,
  input  logic [BANK_W-1:0] acc_bank_i,
  input  logic              ref_req_i,
  input  logic [BANK_W-1:0] ref_bank_i,
  input  logic [NBANK-1:0]  bank_ready_i,
  input  cyc_t              acc_wait_i,
  input  cyc_t              ref_width_i,
  output logic [NBANK-1:0]  ras_o,
  output logic              ack_o,
  output logic              done_o,
  output logic              close_o,
  output logic [BANK_W-1:0] close_bank_o,
  output logic              start_o,
  output logic              start_ref_o,
  output logic [BANK_W-1:0] start_bank_o
);

  seq_state_e        state_q, state_d;
  cyc_t              cnt_q, cnt_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [NBANK-1:0]  ras_q, ras_d;
  logic              cnt_en, finish, start, start_ref;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bank_d    = bank_q;
    ras_d     = ras_q;
    cnt_en    = 1'b0;
    start     = 1'b0;
    start_ref = 1'b0;
    finish    = (state_q != ST_IDLE) && (cnt_q == '0);

    case (state_q)
      ST_IDLE: begin
        if (ref_req_i) begin
          // refresh wins; an access waits even if the refresh bank is locked
          if (bank_ready_i[ref_bank_i]) begin
            start     = 1'b1;
            start_ref = 1'b1;
            state_d   = ST_REF;
            bank_d    = ref_bank_i;
            cnt_d     = ref_width_i - cyc_t'(1);
            cnt_en    = 1'b1;
          end
        end else if (acc_req_i && bank_ready_i[acc_bank_i]) begin
          start   = 1'b1;
          state_d = ST_ACC;
          bank_d  = acc_bank_i;
          cnt_d   = acc_wait_i;
          cnt_en  = 1'b1;
        end
      end
      default: begin
        cnt_en = 1'b1;
        if (finish) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - cyc_t'(1);
        end
      end
    endcase

    if (start) begin
      ras_d         = '0;
      ras_d[bank_d] = 1'b1;
    end else if (finish) begin
      ras_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bank_q  <= '0;
      ras_q   <= '0;
    end else begin
      state_q <= state_d;
      ras_q   <= ras_d;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        bank_q <= bank_d;
      end
    end
  end

  assign ras_o        = ras_q;
  assign ack_o        = (state_q == ST_ACC) && (cnt_q == '0);
  assign done_o       = (state_q == ST_REF) && (cnt_q == '0);
  assign close_o      = finish;
  assign close_bank_o = bank_q;
  assign start_o      = start;
  assign start_ref_o  = start_ref;
  assign start_bank_o = bank_d;

endmodule

// File: rtl/dram_ras_seq.sv
module dram_ras_seq
  import dram_seq_pkg::*;
#(
  parameter  int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int CFG_W  = CODE_W * NBANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_wait_i,
  input  logic [CFG_W-1:0]  cfg_pre_i,
  input  logic [CFG_W-1:0]  cfg_rfw_i,
  input  logic              acc_req_i,
  input  logic [BANK_W-1:0] acc_bank_i,
  input  logic              ref_req_i,
  input  logic [BANK_W-1:0] ref_bank_i,
  output logic [NBANK-1:0]  ras_o,
  output logic              acc_ack_o,
  output logic              ref_done_o
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  cyc_t              wait_cyc [NBANK];
  cyc_t              pre_cyc  [NBANK];
  cyc_t              rfw_cyc  [NBANK];
  logic [NBANK-1:0]  bank_ready;
  logic              fsm_close;
  logic [BANK_W-1:0] fsm_close_bank;
  logic              fsm_start;
  logic              fsm_start_ref;
  logic [BANK_W-1:0] fsm_start_bank;
  cyc_t              sel_wait;
  cyc_t              sel_width;

  dram_timing_decode #(.NBANK(NBANK)) u_decode (
    .cfg_wait_i (cfg_wait_i),
    .cfg_pre_i  (cfg_pre_i),
    .cfg_rfw_i  (cfg_rfw_i),
    .wait_o     (wait_cyc),
    .pre_o      (pre_cyc),
    .rfw_o      (rfw_cyc)
  );

  assign sel_wait  = wait_cyc[acc_bank_i];
  assign sel_width = rfw_cyc[ref_bank_i];

  dram_bank_lock #(.NBANK(NBANK)) u_lock (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .close_i      (fsm_close),
    .close_bank_i (fsm_close_bank),
    .pre_i        (pre_cyc),
    .ready_o      (bank_ready)
  );

  dram_ras_fsm #(.NBANK(NBANK)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .acc_req_i    (acc_req_i),
    .acc_bank_i   (acc_bank_i),
    .ref_req_i    (ref_req_i),
    .ref_bank_i   (ref_bank_i),
    .bank_ready_i (bank_ready),
    .acc_wait_i   (sel_wait),
    .ref_width_i  (sel_width),
    .ras_o        (ras_o),
    .ack_o        (acc_ack_o),
    .done_o       (ref_done_o),
    .close_o      (fsm_close),
    .close_bank_o (fsm_close_bank),
    .start_o      (fsm_start),
    .start_ref_o  (fsm_start_ref),
    .start_bank_o (fsm_start_bank)
  );

endmodule

// File: rtl/dram_ras_seq_chk.sv
module dram_ras_seq_chk #(
  parameter  int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NBANK-1:0]  ras_i,
  input logic              ack_i,
  input logic              done_i,
  input logic              ref_req_i,
  input logic              start_i,
  input logic              start_ref_i,
  input logic [BANK_W-1:0] start_bank_i,
  input logic [NBANK-1:0]  bank_ready_i
);

  a_r8_one_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ras_i));

  a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !ack_i);

  a_r3_ack_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> (ras_i != '0));

  a_r5_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (ras_i == '0));

  a_r4_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> bank_ready_i[start_bank_i]);

  a_r7_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ref_req_i) |-> start_ref_i);

  for (genvar b = 0; b < NBANK; b++) begin : g_gap
    a_r4_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_i[b]) |=> !ras_i[b]);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_quiet: assert (ras_i == '0 && !ack_i && !done_i);
    end
  end

endmodule

bind dram_ras_seq dram_ras_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ras_i        (ras_o),
  .ack_i        (acc_ack_o),
  .done_i       (ref_done_o),
  .ref_req_i    (ref_req_i),
  .start_i      (fsm_start),
  .start_ref_i  (fsm_start_ref),
  .start_bank_i (fsm_start_bank),
  .bank_ready_i (bank_ready)
);

// File: tb/dram_ras_seq_tb.sv
`timescale 1ns/1ps
module dram_ras_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_wait, cfg_pre, cfg_rfw;
  logic       acc_req, ref_req;
  logic [1:0] acc_bank, ref_bank;
  logic [3:0] ras_o;
  logic       acc_ack_o, ref_done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int multi_ras = 0;

  always #2 clk = ~clk;

  dram_ras_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wait_i (cfg_wait),
    .cfg_pre_i  (cfg_pre),
    .cfg_rfw_i  (cfg_rfw),
    .acc_req_i  (acc_req),
    .acc_bank_i (acc_bank),
    .ref_req_i  (ref_req),
    .ref_bank_i (ref_bank),
    .ras_o      (ras_o),
    .acc_ack_o  (acc_ack_o),
    .ref_done_o (ref_done_o)
  );

  // R8: watch every cycle for more than one strobe
  always @(negedge clk) begin
    if (rst_n === 1'b1 && $countones(ras_o) > 1) multi_ras++;
  end

  function automatic int exp_w(input int c);
    return (c > 2) ? 5 : 3 + c;
  endfunction
  function automatic int exp_p(input int c);
    return (c > 2) ? 8 : 4 + 2 * c;
  endfunction
  function automatic int exp_r(input int c);
    return 4 + c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts low negedges after the current one until ras_o[b] is high
  task automatic wait_rise(input int b, output int lo);
    lo = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ras_o[b]) break;
      lo++;
    end
  endtask

  // starts on a negedge with ras_o[b] high, ends on the first low one
  task automatic run_high(input int b, output int hi, output int pos,
                          output int nack, output int ndone);
    hi = 0; pos = 0; nack = 0; ndone = 0;
    for (int i = 0; i < 40; i++) begin
      if (!ras_o[b]) break;
      hi++;
      if (acc_ack_o)  begin nack++;  pos = hi; acc_req = 1'b0; end
      if (ref_done_o) begin ndone++; pos = hi; ref_req = 1'b0; end
      @(negedge clk);
    end
    acc_req = 1'b0;
    ref_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wait = '0; cfg_pre = '0; cfg_rfw = '0;
    acc_req = 1'b0; ref_req = 1'b0; acc_bank = '0; ref_bank = '0;
    repeat (3) @(negedge clk);
    acc_req = 1'b1; ref_req = 1'b1;
    @(negedge clk);
    chk("R9 ras", int'(ras_o), 0);
    chk("R9 ack", int'(acc_ack_o), 0);
    chk("R9 done", int'(ref_done_o), 0);
    acc_req = 1'b0; ref_req = 1'b0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 4; c++) begin
        int lo, hi, pos, na, nd, b2, ba;
        // R10: other banks carry the opposite code
        for (int k = 0; k < 4; k++) begin
          cfg_wait[2*k +: 2] = (k == b) ? 2'(c) : 2'(3 - c);
          cfg_pre [2*k +: 2] = (k == b) ? 2'(c) : 2'(3 - c);
          cfg_rfw [2*k +: 2] = (k == b) ? 2'(c) : 2'(3 - c);
        end
        b2 = (b + 1) % 4;
        ba = (b + 2) % 4;

        // R1 R2 R3 R10: single access
        acc_bank = 2'(b); acc_req = 1'b1;
        wait_rise(b, lo);
        run_high(b, hi, pos, na, nd);
        chk((c == 3) ? "R2 R10 ras width" : "R1 R10 ras width", hi, exp_w(c) + 1);
        chk((c == 3) ? "R2 ack position" : "R1 ack position", pos, exp_w(c) + 1);
        chk("R3 ack count", na, 1);

        // R4: request same bank on the closing cycle
        acc_req = 1'b1;
        wait_rise(b, lo);
        chk("R4 precharge gap", lo + 1, exp_p(c));
        run_high(b, hi, pos, na, nd);
        chk("R3 second ack", na, 1);
        repeat (10) @(negedge clk);

        // R5: refresh width and done pulse
        ref_bank = 2'(b); ref_req = 1'b1;
        wait_rise(b, lo);
        run_high(b, hi, pos, na, nd);
        chk("R5 refresh width", hi, exp_r(c));
        chk("R5 done position", pos, exp_r(c));
        chk("R5 done count", nd, 1);
        repeat (10) @(negedge clk);

        // R6: another bank opens right after a close
        acc_bank = 2'(b); acc_req = 1'b1;
        wait_rise(b, lo);
        run_high(b, hi, pos, na, nd);
        acc_bank = 2'(b2); acc_req = 1'b1;
        wait_rise(b2, lo);
        chk("R6 next bank delay", lo, 0);
        run_high(b2, hi, pos, na, nd);
        repeat (10) @(negedge clk);

        // R7: simultaneous refresh and access
        ref_bank = 2'(b); ref_req = 1'b1;
        acc_bank = 2'(ba); acc_req = 1'b1;
        @(negedge clk);
        chk("R7 refresh bank opened", int'(ras_o[b]), 1);
        chk("R7 access bank held", int'(ras_o[ba]), 0);
        acc_req = 1'b1;
        run_high(b, hi, pos, na, nd);
        chk("R7 no ack during refresh", na, 0);
        acc_req = 1'b1;
        wait_rise(ba, lo);
        run_high(ba, hi, pos, na, nd);
        chk("R7 access after refresh", na, 1);
        repeat (10) @(negedge clk);
      end
    end

    chk("R8 single strobe", multi_ras, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule